// File: doc/BRIEF.md
# Capture/Compare Timer with Sticky Event Flags

This block is a free-running up-counter with three event sources: a captured edge on an external input, a match between the counter and a programmed compare value, and the counter wrapping from all ones to zero. Each event latches a flag in a read-only status byte. A flag is cleared only by a two-step software handshake. First the status byte is read while the flag is 1. Then the low byte of the register that belongs to that event is accessed. The ordinary block reset does not disturb the flags. Software learns about every event even across a reset, and a single stray access cannot lose one.

The counter advances on cycles where `tick` is high, so any prescaler sits outside the block. A capture edge, of a polarity chosen in the control register, copies the counter into a capture register after a two-stage synchroniser. A compare match drives the programmed level onto an internal compare output. A pin-enable bit then chooses between that output and a plain port data bit for the shared `pin_out` line.

Registers sit on a byte bus with single-cycle read and write strobes. Read data is registered and appears on `rd_data` in the cycle after the read strobe.

Top module: `capcmp_timer`

## Requirements
- R1: The status byte is at address 1. Bit 7 is the capture flag, bit 6 the compare flag and bit 5 the wrap flag, and bits 4..0 read 0. Any read returns its data on `rd_data` one cycle after `bus_rd`.
- R2: A write to the status address changes no flag.
- R3: Reset leaves all three flags unchanged. It clears the control byte (address 0), the port data bit (address 8), the counter and the compare value, so `pin_out` reads 0 after reset.
- R4: Control bit 0 selects the capture edge (1 = rising, 0 = falling). An edge of that polarity on `cap_in` copies the counter into the capture register and sets the capture flag. The capture register is read at address 2 (high byte) and address 3 (low byte). An edge of the other polarity has no effect.
- R5: The capture flag clears only when a status read that saw it at 1 is followed by a read of address 3. A read of address 3 without such a prior status read leaves the flag set.
- R6: When a tick moves the counter onto the compare value, the compare flag sets and the compare output takes control bit 1. The compare value is written at address 4 (high byte) and address 5 (low byte). The compare output does not change at any other time.
- R7: The compare flag clears when a status read that saw it at 1 is followed by a read or a write of address 5.
- R8: A tick with the counter at all ones wraps it to 0 and sets the wrap flag. The counter is read at address 6 (high byte) and address 7 (low byte), and writes to these addresses leave the counter unchanged. The wrap flag clears when an armed status read is followed by a read or a write of address 7. Without the status read, an access to address 7 does not clear it.
- R9: When control bit 2 is 1, `pin_out` follows the compare output. When it is 0, `pin_out` follows bit 0 of the port byte at address 8.
- R10: If an event sets a flag in the same cycle as its armed clearing access, the flag stays 1.
- R11: The counter holds its value on cycles with `tick` low and adds 1 on cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; does not touch the event flags |
| tick | input | 1 | Counter advance enable |
| cap_in | input | 1 | Asynchronous capture input |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_out | output | 1 | Shared pin: compare output or port bit |

## Verification
The event logic and the clearing handshake can act on the same flag in the same cycle. The bench provokes this for the compare flag. It arms the flag with a status read, then raises `tick` in the very cycle where it writes the compare low byte, with the compare value set one above the current count. The match lands on the clearing edge, and a later status read must still show bit 6 at 1. A following armed read of the low byte, with no event, must then clear the flag, which shows that the handshake itself still works.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  // register addresses on the byte bus
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_STAT = 1;
  localparam int unsigned REG_CAPH = 2;
  localparam int unsigned REG_CAPL = 3;
  localparam int unsigned REG_CMPH = 4;
  localparam int unsigned REG_CMPL = 5;
  localparam int unsigned REG_CNTH = 6;
  localparam int unsigned REG_CNTL = 7;
  localparam int unsigned REG_PORT = 8;

  // event / flag indices; status bit = DATA_W-3+index
  localparam int unsigned NUM_EVT = 3;
  localparam int unsigned EV_WRAP = 0;
  localparam int unsigned EV_CMP  = 1;
  localparam int unsigned EV_CAP  = 2;

  typedef struct packed {
    logic pin_en;   // bit 2
    logic out_lvl;  // bit 1
    logic rise;     // bit 0
  } ctrl_t;

endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic evt_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  assign level = sync_q[STAGES-1];

  // synchroniser chain runs through reset so it is settled on release
  always_ff @(posedge clk) begin
    sync_q <= {sync_q[STAGES-2:0], pin_i};
    prev_q <= level;
  end

  always_comb begin
    if (rst)
      evt_o = 1'b0;
    else if (rise_sel_i)
      evt_o = level & ~prev_q;
    else
      evt_o = ~level & prev_q;
  end

endmodule

// File: rtl/capcmp_count.sv
module capcmp_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cmp_evt,
  output logic             wrap_evt
);

  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt  = cnt_q + CNT_W'(1);
  assign cmp_evt  = !rst && tick && (cnt_nxt == cmp_val);
  assign wrap_evt = !rst && tick && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/capcmp_flag.sv
module capcmp_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic armed_q;

  // flag has no reset: it survives the block reset by design
  always_ff @(posedge clk) begin
    if (set_i)
      flag_q <= 1'b1;
    else if (clr_i && armed_q)
      flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      armed_q <= 1'b0;
    else if (arm_i)
      armed_q <= flag_q;
    else if (clr_i)
      armed_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cap_in,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              pin_out
);

  localparam int DBL_W    = 2 * DATA_W;
  localparam int STAT_LSB = DATA_W - NUM_EVT;

  // address decode
  logic sel_ctrl, sel_stat, sel_caph, sel_capl, sel_cmph, sel_cmpl;
  logic sel_cnth, sel_cntl, sel_port, bus_acc;

  assign sel_ctrl = bus_addr == ADDR_W'(REG_CTRL);
  assign sel_stat = bus_addr == ADDR_W'(REG_STAT);
  assign sel_caph = bus_addr == ADDR_W'(REG_CAPH);
  assign sel_capl = bus_addr == ADDR_W'(REG_CAPL);
  assign sel_cmph = bus_addr == ADDR_W'(REG_CMPH);
  assign sel_cmpl = bus_addr == ADDR_W'(REG_CMPL);
  assign sel_cnth = bus_addr == ADDR_W'(REG_CNTH);
  assign sel_cntl = bus_addr == ADDR_W'(REG_CNTL);
  assign sel_port = bus_addr == ADDR_W'(REG_PORT);
  assign bus_acc  = bus_rd | bus_wr;

  // programmable state
  ctrl_t            ctrl_q;
  logic [DBL_W-1:0] cmp_q;
  logic             port_q;
  logic [CNT_W-1:0] cap_q;
  logic             cmp_out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      port_q <= 1'b0;
    end else if (bus_wr) begin
      if (sel_ctrl) ctrl_q <= ctrl_t'(bus_wdata[2:0]);
      if (sel_cmph) cmp_q[DBL_W-1:DATA_W] <= bus_wdata;
      if (sel_cmpl) cmp_q[DATA_W-1:0] <= bus_wdata;
      if (sel_port) port_q <= bus_wdata[0];
    end
  end

  // counter with compare and wrap detection
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_EVT-1:0] flag_q;
  logic [NUM_EVT-1:0] clr_vec;

  capcmp_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cmp_val  (cmp_q[CNT_W-1:0]),
    .cnt_q    (cnt_q),
    .cmp_evt  (evt_vec[EV_CMP]),
    .wrap_evt (evt_vec[EV_WRAP])
  );

  // capture path
  capcmp_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (cap_in),
    .rise_sel_i (ctrl_q.rise),
    .evt_o      (evt_vec[EV_CAP])
  );

  always_ff @(posedge clk) begin
    if (rst)
      cap_q <= '0;
    else if (evt_vec[EV_CAP])
      cap_q <= cnt_q;
  end

  // clearing accesses per flag
  assign clr_vec[EV_CAP]  = bus_rd  && sel_capl;
  assign clr_vec[EV_CMP]  = bus_acc && sel_cmpl;
  assign clr_vec[EV_WRAP] = bus_acc && sel_cntl;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    capcmp_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (evt_vec[i]),
      .arm_i  (bus_rd && sel_stat),
      .clr_i  (clr_vec[i]),
      .flag_o (flag_q[i])
    );
  end

  // compare output and shared pin
  always_ff @(posedge clk) begin
    if (rst)
      cmp_out_q <= 1'b0;
    else if (evt_vec[EV_CMP])
      cmp_out_q <= ctrl_q.out_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)
      pin_out <= 1'b0;
    else
      pin_out <= ctrl_q.pin_en ? cmp_out_q : port_q;
  end

  // read mux, registered
  logic [DBL_W-1:0]  cap_w, cnt_w;
  logic [DATA_W-1:0] stat_w, rd_mux;

  assign cap_w = DBL_W'(cap_q);
  assign cnt_w = DBL_W'(cnt_q);

  always_comb begin
    stat_w = '0;
    stat_w[STAT_LSB +: NUM_EVT] = flag_q;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) rd_mux = DATA_W'(ctrl_q);
    if (sel_stat) rd_mux = stat_w;
    if (sel_caph) rd_mux = cap_w[DBL_W-1:DATA_W];
    if (sel_capl) rd_mux = cap_w[DATA_W-1:0];
    if (sel_cmph) rd_mux = cmp_q[DBL_W-1:DATA_W];
    if (sel_cmpl) rd_mux = cmp_q[DATA_W-1:0];
    if (sel_cnth) rd_mux = cnt_w[DBL_W-1:DATA_W];
    if (sel_cntl) rd_mux = cnt_w[DATA_W-1:0];
    if (sel_port) rd_mux = DATA_W'(port_q);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (bus_rd)
      rd_data <= rd_mux;
  end

endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk
  import capcmp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               bus_rd,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  rd_data,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [NUM_EVT-1:0] flag_q,
  input logic [NUM_EVT-1:0] evt_vec
);

  logic stat_rd, stat_wr, capl_rd;
  assign stat_rd = bus_rd && bus_addr == ADDR_W'(REG_STAT);
  assign stat_wr = bus_wr && bus_addr == ADDR_W'(REG_STAT);
  assign capl_rd = bus_rd && bus_addr == ADDR_W'(REG_CAPL);

  assert_status_pad_zero_R1: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> rd_data[DATA_W-NUM_EVT-1:0] == '0);

  assert_status_write_inert_R2: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && evt_vec == '0) |=> $stable(flag_q));

  assert_cap_clear_needs_read_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q[EV_CAP]) |-> $past(capl_rd));

  assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == {CNT_W{1'b1}}) |=> flag_q[EV_WRAP]);

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
    evt_vec[EV_CMP] |=> flag_q[EV_CMP]);

  assert_count_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

endmodule

bind capcmp_timer capcmp_timer_chk #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rd_data  (rd_data),
  .cnt_q    (cnt_q),
  .flag_q   (flag_q),
  .evt_vec  (evt_vec)
);

// File: tb/sim_capcmp_timer.sv
module sim_capcmp_timer;
  import capcmp_pkg::*;

  localparam int CLK_P = 10;
  localparam logic [7:0] ST_CAP  = 8'h80;
  localparam logic [7:0] ST_CMP  = 8'h40;
  localparam logic [7:0] ST_WRAP = 8'h20;

  logic       clk = 1'b0, rst = 1'b1, tick = 1'b0, cap_in = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd_data;
  logic       pin_out;

  always #(CLK_P/2) clk = ~clk;

  capcmp_timer #(.CNT_W(16), .DATA_W(8), .ADDR_W(4), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .cap_in(cap_in),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .pin_out(pin_out)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] m_cnt;

  // counter expectation from R11/R3: +1 per ticked cycle, 0 on reset
  always @(posedge clk) begin
    if (rst) m_cnt <= 16'd0;
    else if (tick) m_cnt <= m_cnt + 16'd1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = 4'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_cmp(input logic [15:0] v);
    wr(REG_CMPH, v[15:8]);
    wr(REG_CMPL, v[7:0]);
  endtask

  task automatic clear_all();
    logic [7:0] d;
    rd(REG_STAT, d);
    rd(REG_CAPL, d);
    rd(REG_CMPL, d);
    rd(REG_CNTL, d);
    rd(REG_STAT, d);
    chk("R5 R7 R8 clear all flags", d, 8'h00);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0]  d, h;
    logic [15:0] exp_v;
    logic        lvl, prev_lvl;
    @(negedge clk);
    idle(5);
    rst = 1'b0;
    idle(4);

    // reset state
    rd(REG_CTRL, d);  chk("R3 ctrl after reset", d, 8'h00);
    rd(REG_CNTH, h);  rd(REG_CNTL, d);
    chk("R3 counter after reset", {h, d}, 16'h0000);
    chk("R3 pin after reset", pin_out, 1'b0);
    rd(REG_STAT, d);  chk("R1 status pad bits", d & 8'h1F, 8'h00);
    clear_all();

    // counter hold and advance
    idle(10);
    rd(REG_CNTL, d);  chk("R11 hold without tick", d, 8'h00);
    tick_n(37);
    rd(REG_CNTH, h);  rd(REG_CNTL, d);
    chk("R11 advance by ticks", {h, d}, 16'd37);

    // port mux with pin function off
    wr(REG_PORT, 8'h01); idle(2);
    chk("R9 port bit 1", pin_out, 1'b1);
    wr(REG_PORT, 8'h00); idle(2);
    chk("R9 port bit 0", pin_out, 1'b0);

    // capture sweep: both polarities, several count values
    for (int p = 1; p >= 0; p--) begin
      wr(REG_CTRL, 8'(p));
      for (int k = 0; k < 3; k++) begin
        cap_in = (p == 1) ? 1'b0 : 1'b1;   // inactive level (maybe an ignored edge)
        idle(5);
        rd(REG_STAT, d);
        chk("R4 wrong edge ignored", d & ST_CAP, 8'h00);
        tick_n((k == 1) ? 16'h1F0 : k + 3);
        exp_v = m_cnt;
        cap_in = (p == 1) ? 1'b1 : 1'b0;   // active edge
        idle(5);
        rd(REG_CAPL, d);  chk("R4 capture low byte", d, exp_v[7:0]);
        rd(REG_STAT, d);  chk("R5 unarmed low read keeps flag", d & ST_CAP, ST_CAP);
        rd(REG_CAPH, d);  chk("R4 capture high byte", d, exp_v[15:8]);
        rd(REG_CAPL, d);
        rd(REG_STAT, d);  chk("R5 armed low read clears", d & ST_CAP, 8'h00);
      end
    end

    // compare sweep: boundary before and at the match, alternating levels
    prev_lvl = 1'b0;
    for (int i = 0; i < 4; i++) begin
      int off;
      off = (i == 0) ? 1 : (i == 1) ? 2 : (i == 2) ? 7 : 300;
      lvl = ~prev_lvl;
      wr(REG_CTRL, {5'b0, 1'b1, lvl, 1'b1});
      set_cmp(m_cnt + 16'(off));
      tick_n(off - 1);
      rd(REG_STAT, d);  chk("R6 no flag before match", d & ST_CMP, 8'h00);
      chk("R6 output waits for match", pin_out, prev_lvl);
      tick_n(1);
      rd(REG_STAT, d);  chk("R6 flag at match", d & ST_CMP, ST_CMP);
      chk("R6 R9 output takes level", pin_out, lvl);
      if (i[0]) wr(REG_CMPL, d);
      else      rd(REG_CMPL, d);
      rd(REG_STAT, d);  chk("R7 clear by low access", d & ST_CMP, 8'h00);
      prev_lvl = lvl;
    end

    // set and clear in the same cycle
    set_cmp(m_cnt + 16'd1);
    tick_n(1);
    exp_v = m_cnt + 16'd2;
    set_cmp(exp_v);
    tick_n(1);
    rd(REG_STAT, d);  chk("R6 flag set before collision", d & ST_CMP, ST_CMP);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'(REG_CMPL); bus_wdata = exp_v[7:0];
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(REG_STAT, d);  chk("R10 set wins over clear", d & ST_CMP, ST_CMP);
    rd(REG_CMPL, d);
    rd(REG_STAT, d);  chk("R7 clear after collision", d & ST_CMP, 8'h00);

    // wrap
    tick_n(16'hFFFF - m_cnt);
    rd(REG_CNTH, h);  rd(REG_CNTL, d);
    chk("R8 counter at top", {h, d}, 16'hFFFF);
    rd(REG_STAT, d);  chk("R8 no wrap flag yet", d & ST_WRAP, 8'h00);
    tick_n(1);
    rd(REG_CNTL, d);  chk("R8 wrapped low", d, 8'h00);
    rd(REG_CNTH, d);  chk("R8 wrapped high", d, 8'h00);
    rd(REG_STAT, d);  chk("R8 wrap flag, unarmed access kept it", d & ST_WRAP, ST_WRAP);
    wr(REG_CNTL, 8'h55);
    rd(REG_STAT, d);  chk("R8 cleared by low write", d & ST_WRAP, 8'h00);
    rd(REG_CNTL, d);  chk("R8 counter write ignored", d, 8'h00);

    // flags across status writes and reset
    clear_all();
    wr(REG_CTRL, 8'h01);
    cap_in = 1'b0; idle(5);
    cap_in = 1'b1; idle(5);
    set_cmp(m_cnt + 16'd1);
    tick_n(1);
    rd(REG_STAT, d);  chk("R4 R6 two flags set", d, ST_CAP | ST_CMP);
    wr(REG_STAT, 8'hFF);
    rd(REG_STAT, d);  chk("R2 write ones ignored", d, ST_CAP | ST_CMP);
    wr(REG_STAT, 8'h00);
    rd(REG_STAT, d);  chk("R2 write zeros ignored", d, ST_CAP | ST_CMP);
    wr(REG_CTRL, 8'h07);
    wr(REG_PORT, 8'h01);
    rst = 1'b1; idle(3); rst = 1'b0; idle(1);
    rd(REG_STAT, d);  chk("R3 flags survive reset", d, ST_CAP | ST_CMP);
    rd(REG_CTRL, d);  chk("R3 ctrl cleared", d, 8'h00);
    rd(REG_PORT, d);  chk("R3 port cleared", d, 8'h00);
    rd(REG_CNTL, d);  chk("R3 counter cleared", d, 8'h00);
    chk("R3 R9 pin is port function", pin_out, 1'b0);
    rd(REG_CAPL, d);
    rd(REG_STAT, d);  chk("R5 capture cleared after reset", d, ST_CMP);
    clear_all();

    summary();
  end

endmodule